// File: doc/BRIEF.md
# Card Data Line Direction Arbiter

This block joins a set of open-drain card data lanes (one main data lane and up to two auxiliary lanes) to their matching host-side lanes. No pin selects the direction. Each lane watches both of its lines and makes the line that falls first the source. It then pulls the other line low for as long as the source stays low. Each line is modelled as a wired-AND with a pull-up. The block sees the resolved level on a line input and asserts a pull-low output to drive that line.

A reception-enable input from the session sequencer gates all activity. While it is low, the card lines are held low and the host lines are left to their pull-ups. When it rises, a lane arms itself. It starts to look for edges only after both of its lines have been seen high, so the card line rising out of its forced-low state is not taken as traffic. Once a lane is locked, activity on its output side has no effect until the lock is released. The lock is released when both lines are seen high again.

Top module: `card_io_dir_arb`

## Requirements
- R1: While rst_ni is low, every card_pull_o bit is 1 and every host_pull_o bit is 0.
- R2: While rx_en_i is 0, every card_pull_o bit is 1 and every host_pull_o bit is 0, with no clock edge needed. The lane lock is cleared at the next edge.
- R3: After rx_en_i rises, a lane drives neither of its lines until both lines have been sampled high. A low level that is already present on either line during this time is never captured as an edge.
- R4: In an idle lane, a falling edge on the card line makes the card the source. host_pull_o then equals the inverse of the card line. It is asserted at the (SYNC_STAGES+1)th rising edge after the card line falls, and not before that edge.
- R5: In an idle lane, a falling edge on the host line makes the host the source, and card_pull_o then copies the host line low.
- R6: If both lines of an idle lane are first sampled low at the same edge, the card side wins and the card line is never driven by the lane.
- R7: While a lane is locked, a low level on its output-side line changes neither pull output of that lane.
- R8: A locked lane releases, and returns to idle, once its source line is high and its output line is sampled high. After release, either direction can be captured again.
- R9: Each lane arbitrates independently, so activity on one lane leaves the pull outputs of the other lanes unchanged.
- R10: Dropping rx_en_i during a lock releases the host line and forces the card line low. The lane must arm again before it locks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rx_en_i | input | 1 | Reception enable from the session sequencer |
| card_i | input | NUM_LANES | Resolved level of each card-side line |
| host_i | input | NUM_LANES | Resolved level of each host-side line |
| card_pull_o | output | NUM_LANES | Pull-low drive for each card-side line |
| host_pull_o | output | NUM_LANES | Pull-low drive for each host-side line |

## Verification
The bench builds the block with NUM_LANES=3 and SYNC_STAGES=2. With three lanes, one lane can be locked while the other lanes are held quiet or driven in the opposite direction, which is how independence is checked. With two synchronizer stages, the capture latency becomes a fixed count of three edges that can be checked cycle by cycle. The bench models every line as a wired-AND of the block's pull output and a device pull output, so output-side activity, simultaneous falls and deactivation in the middle of a lock are all shown through the resolved line levels.

// File: rtl/card_io_pkg.sv
package card_io_pkg;
  typedef enum logic [2:0] {
    LN_OFF,
    LN_ARM,
    LN_IDLE,
    LN_C2H,
    LN_H2C
  } lane_st_e;
endpackage

// File: rtl/card_io_sync.sv
module card_io_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] sr_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) sr_q <= RST_VAL;
        else         sr_q <= d_i;
      end
    end else begin : g_many
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) sr_q <= {STAGES{RST_VAL}};
        else         sr_q <= {sr_q[STAGES-2:0], d_i};
      end
    end
  endgenerate

  assign q_o = sr_q[STAGES-1];
endmodule

// File: rtl/card_io_lane.sv
module card_io_lane
  import card_io_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic rx_en_i,
  input  logic card_i,
  input  logic host_i,
  output logic card_pull_o,
  output logic host_pull_o
);
  logic     c_s, h_s, c_q, h_q;
  logic     c_fall, h_fall, both_hi;
  lane_st_e st_q, st_d;

  // card line starts low (forced), host line starts high
  card_io_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sync_c (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(card_i), .q_o(c_s)
  );
  card_io_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync_h (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(host_i), .q_o(h_s)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      c_q  <= 1'b0;
      h_q  <= 1'b1;
      st_q <= LN_OFF;
    end else begin
      c_q  <= c_s;
      h_q  <= h_s;
      st_q <= st_d;
    end
  end

  assign c_fall  = c_q & ~c_s;
  assign h_fall  = h_q & ~h_s;
  assign both_hi = c_s & h_s;

  always_comb begin
    st_d = st_q;
    if (!rx_en_i) begin
      st_d = LN_OFF;
    end else begin
      unique case (st_q)
        LN_OFF:  st_d = LN_ARM;
        LN_ARM:  if (both_hi) st_d = LN_IDLE;
        LN_IDLE: begin
          if (c_fall)      st_d = LN_C2H;  // card wins a tie
          else if (h_fall) st_d = LN_H2C;
        end
        LN_C2H:  if (both_hi) st_d = LN_IDLE;
        LN_H2C:  if (both_hi) st_d = LN_IDLE;
        default: st_d = LN_OFF;
      endcase
    end
  end

  assign card_pull_o = ~rx_en_i | (st_q == LN_OFF) | ((st_q == LN_H2C) & ~h_s);
  assign host_pull_o = rx_en_i & (st_q == LN_C2H) & ~c_s;

  a_r10_drop_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rx_en_i |=> (st_q == LN_OFF));
  a_r3_arm_waits: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_en_i && st_q == LN_ARM && !(c_s && h_s)) |=> (st_q == LN_ARM || st_q == LN_OFF));
  a_r7_lock_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_en_i && st_q == LN_C2H && !c_s) |=> (st_q == LN_C2H || !$past(rx_en_i) || !rx_en_i || st_q == LN_OFF));
  a_r7_out_ignored: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_en_i && st_q == LN_H2C && !h_s) |=> (st_q inside {LN_H2C, LN_OFF}));
  a_r5_one_drive: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_en_i |-> !(card_pull_o && host_pull_o));
  a_r8_release: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_en_i && st_q inside {LN_C2H, LN_H2C} && c_s && h_s) |=> (st_q inside {LN_IDLE, LN_OFF}));
endmodule

// File: rtl/card_io_dir_arb.sv
module card_io_dir_arb #(
  parameter int NUM_LANES   = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 rx_en_i,
  input  logic [NUM_LANES-1:0] card_i,
  input  logic [NUM_LANES-1:0] host_i,
  output logic [NUM_LANES-1:0] card_pull_o,
  output logic [NUM_LANES-1:0] host_pull_o
);
  generate
    for (genvar g = 0; g < NUM_LANES; g++) begin : g_lane
      card_io_lane #(.SYNC_STAGES(SYNC_STAGES)) u_lane (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .rx_en_i    (rx_en_i),
        .card_i     (card_i[g]),
        .host_i     (host_i[g]),
        .card_pull_o(card_pull_o[g]),
        .host_pull_o(host_pull_o[g])
      );
    end
  endgenerate

  a_r1_reset_state: assert property (@(posedge clk_i)
    !rst_ni |-> (&card_pull_o && !(|host_pull_o)));
  a_r2_disabled: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rx_en_i |-> (&card_pull_o && !(|host_pull_o)));
endmodule

// File: tb/card_io_dir_arb_tb.sv
module card_io_dir_arb_tb;
  localparam int N = 3;
  localparam int SS = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic rx_en = 1'b0;
  logic [N-1:0] cdev = '0, hdev = '0;
  logic [N-1:0] card_pull, host_pull, card_ln, host_ln;
  int n_chk = 0, n_bad = 0;

  always #4 clk = ~clk;

  assign card_ln = ~(card_pull | cdev);
  assign host_ln = ~(host_pull | hdev);

  card_io_dir_arb #(.NUM_LANES(N), .SYNC_STAGES(SS)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .rx_en_i(rx_en),
    .card_i(card_ln), .host_i(host_ln),
    .card_pull_o(card_pull), .host_pull_o(host_pull)
  );

  // {req[3:0], rx, card_dev, host_dev, exp_card_line, exp_host_line}, lane 0
  localparam logic [8:0] VEC [17] = '{
    {4'd2,  5'b00001},
    {4'd3,  5'b10011},
    {4'd4,  5'b11000},
    {4'd7,  5'b11100},
    {4'd7,  5'b11000},
    {4'd8,  5'b10011},
    {4'd5,  5'b10100},
    {4'd7,  5'b11100},
    {4'd7,  5'b10100},
    {4'd8,  5'b10011},
    {4'd5,  5'b10100},
    {4'd10, 5'b00100},
    {4'd10, 5'b00001},
    {4'd3,  5'b10110},
    {4'd3,  5'b10011},
    {4'd5,  5'b10100},
    {4'd8,  5'b10011}
  };

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic settle();
    repeat (10) @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    // R1 reset state
    repeat (3) @(negedge clk);
    chk("R1 card_pull", 8'(card_pull), 8'h7);
    chk("R1 host_pull", 8'(host_pull), 8'h0);
    rst_n = 1'b1;
    settle();
    chk("R2 idle off card", 8'(card_pull), 8'h7);

    for (int i = 0; i < 17; i++) begin
      @(negedge clk);
      rx_en   = VEC[i][4];
      cdev[0] = VEC[i][3];
      hdev[0] = VEC[i][2];
      settle();
      chk($sformatf("R%0d vec%0d", VEC[i][8:5], i),
          8'({card_ln[0], host_ln[0]}), 8'(VEC[i][1:0]));
    end

    // R4 exact latency on lane 1, R9 others untouched
    @(negedge clk);
    cdev[1] = 1'b1;
    repeat (SS) @(posedge clk);
    @(negedge clk);
    chk("R4 early", 8'(host_pull[1]), 8'h0);
    @(posedge clk);
    @(negedge clk);
    chk("R4 on time", 8'(host_pull[1]), 8'h1);
    chk("R9 other lanes", 8'({host_pull[2], host_pull[0], card_pull}), 8'h0);

    // R9 lane 2 locks opposite way while lane 1 holds
    hdev[2] = 1'b1;
    settle();
    chk("R9 lane2 h2c", 8'({card_pull[2], host_pull[1], card_pull[1]}), 8'b110);

    // R10 immediate drop in a lock
    rx_en = 1'b0;
    #1;
    chk("R10 comb drop", 8'({card_pull, host_pull}), 8'h38);
    cdev[1] = 1'b0;
    hdev[2] = 1'b0;
    settle();
    rx_en = 1'b1;
    settle();
    chk("R10 re-armed idle", 8'({card_ln, host_ln}), 8'h3f);

    // R6 simultaneous falls on lane 2
    cdev[2] = 1'b1;
    hdev[2] = 1'b1;
    settle();
    cdev[2] = 1'b0;
    settle();
    chk("R6 card not driven", 8'({card_pull[2], card_ln[2], host_ln[2]}), 8'b010);
    hdev[2] = 1'b0;
    settle();
    chk("R8 release after tie", 8'({card_ln[2], host_ln[2]}), 8'b11);
    hdev[2] = 1'b1;
    settle();
    chk("R8 new direction", 8'(card_pull[2]), 8'h1);
    hdev[2] = 1'b0;
    settle();
    chk("R8 final idle", 8'({card_ln, host_ln}), 8'h3f);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule